// File: doc/BRIEF.md
# Serial Management Register Slave for an Ethernet PHY

This block is the management end of an Ethernet PHY. A station manager reaches it over a two-wire serial bus: a management clock and a bidirectional data line. Each frame starts with a run of ones, then carries an operation, a 5-bit device address and a 5-bit register address, and ends with 16 data bits. The block answers only frames that carry its own device address. It holds a control word, a read-only status word, an ability advertisement, a read-only mirror of the link partner's abilities, an interrupt word and a miscellaneous word that holds the interrupt pin polarity.

While reset is held, the block samples strap inputs on every clock. They set its device address and seed the speed, duplex and auto-negotiation control bits, and they seed the matching ability bits in the advertisement. Link events arrive as single-cycle pulses on eight event inputs. Each pulse latches a condition bit. Reading the interrupt word returns the condition bits and clears them. The interrupt pin is active whenever a condition bit is set and its enable bit is set. The pin's active level is programmable.

The bus inputs are brought onto the system clock through a synchronizer, and a rising management clock edge becomes a one-cycle bit strobe. The frame decoder is a state machine with these states:
- `ST_PRE` counts consecutive ones. On a zero it moves to `ST_START` if at least 32 ones were seen, and otherwise it clears the count.
- `ST_START` needs a one to reach `ST_OP`, and otherwise returns to `ST_PRE`.
- `ST_OP`, `ST_PHY` and `ST_REG` each collect their field (2, 5 and 5 bits) and then pass to the next state.
- `ST_TA` takes two bits and passes to `ST_DATA`.
- `ST_DATA` takes 16 bits and returns to `ST_PRE`.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The device address is the value on `strap_phyad` while reset is held, with 00001 as the strapped default. A frame with any other address causes no drive and no register change.
- R2: After reset, the control word (register 0x00) has bit 13 equal to the speed strap (1 = 100 Mb/s), bit 12 equal to the auto-negotiation strap and bit 8 equal to the duplex strap (1 = full). All other bits are 0.
- R3: After reset, the advertisement (register 0x04) reads bits 4:0 as 00001 and bit 5 (10 half) as 1. Bit 6 (10 full) equals duplex, bit 7 (100 half) equals speed, and bit 8 (100 full) equals speed AND duplex.
- R4: On a read addressed to this device, `mdio_oe` is high from the rising clock edge of the first turnaround bit through the edge of the last data bit. The second turnaround bit is 0, and the data follows MSB first. `mdio_oe` is low at all other times.
- R5: A write (opcode 01) to register 0x00 stores only bits 14, 13, 12, 11, 10 and 8. A write to 0x04 stores only bits 8:5. A write to 0x1B stores only enables 15:8. A write to 0x1F stores only bit 9. Writes to 0x01 and 0x05 change nothing.
- R6: Registers other than 0x00, 0x01, 0x04, 0x05, 0x1B and 0x1F read as 0, and writes to them have no effect.
- R7: Register 0x01 reads 0xF009, with bit 2 set to `link_up` and bit 5 set to `aneg_done`. Register 0x05 reads `lp_ability`.
- R8: A pulse on `irq_evt[i]` sets condition bit i of register 0x1B (bits 7:0). A read of 0x1B returns the conditions and clears them, except that a condition pulsed in the clearing cycle stays set.
- R9: `irq_o` is active when any condition bit has its enable bit (bit i+8) set. The active level is high when 0x1F bit 9 is 1 and low when it is 0. Bit 9 resets to 0, so an idle pin is high.
- R10: A frame with fewer than 32 preamble ones, or with opcode 00 or 11, causes no drive and no register change.
- R11: A read request and a write commit never occur in the same cycle, and the data line is driven only in answer to a read that matches the device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line output enable |
| strap_phyad | input | 5 | Device address strap |
| strap_speed | input | 1 | Speed strap, 1 = 100 Mb/s |
| strap_duplex | input | 1 | Duplex strap, 1 = full duplex |
| strap_aneg | input | 1 | Auto-negotiation enable strap |
| link_up | input | 1 | Link status level shown in the status word |
| aneg_done | input | 1 | Auto-negotiation complete level shown in the status word |
| lp_ability | input | 16 | Link partner ability word |
| irq_evt | input | 8 | Single-cycle interrupt event pulses |
| irq_o | output | 1 | Interrupt pin with programmable polarity |

## Verification
Directed frames cover several cases:
- Each implemented register and an unimplemented one. Their reads distinguish writable bits from read-only bits and from unmapped space.
- Frames with a foreign address, a short preamble and an illegal opcode. These check that only well-formed frames addressed to this device act.
- An event input held high across the clearing read. This separates the clear-on-read path from the event-priority path.

A seeded random run then mixes reads, writes, foreign addresses and event bursts against a bench model, which covers enable and polarity combinations of the interrupt pin. A second reset with different straps checks that the address and the seeded control and advertisement bits follow the straps, and do not come from fixed defaults.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [ADDR_W-1:0] RA_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] RA_STAT = 5'h01;
    localparam logic [ADDR_W-1:0] RA_ADV  = 5'h04;
    localparam logic [ADDR_W-1:0] RA_LPA  = 5'h05;
    localparam logic [ADDR_W-1:0] RA_IRQ  = 5'h1B;
    localparam logic [ADDR_W-1:0] RA_MISC = 5'h1F;

    localparam logic [REG_W-1:0] CTRL_WMASK = 16'h7D00;
    localparam logic [REG_W-1:0] ADV_WMASK  = 16'h01E0;
    localparam logic [REG_W-1:0] ADV_SEL    = 16'h0001;
    localparam logic [REG_W-1:0] STAT_FIXED = 16'hF009;
    localparam int               POL_BIT    = 9;

endpackage

// File: rtl/phy_strap_latch.sv
module phy_strap_latch
    import phy_mgmt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] strap_phyad,
    input  logic          strap_speed,
    input  logic          strap_duplex,
    input  logic          strap_aneg,
    output logic [AW-1:0] my_addr,
    output logic [RW-1:0] ctrl_seed,
    output logic [RW-1:0] adv_seed
);

    // Address follows the strap pins for as long as reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            my_addr <= strap_phyad;
        end
    end

    always_comb begin
        ctrl_seed     = '0;
        ctrl_seed[13] = strap_speed;
        ctrl_seed[12] = strap_aneg;
        ctrl_seed[8]  = strap_duplex;
        adv_seed      = '0;
        adv_seed[8]   = strap_speed & strap_duplex;
        adv_seed[7]   = strap_speed;
        adv_seed[6]   = strap_duplex;
        adv_seed[5]   = 1'b1;
    end

    // R1: once out of reset the address never moves
    p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(my_addr));

endmodule

// File: rtl/phy_mdio_fsm.sv
module phy_mdio_fsm
    import phy_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DW      = REG_W,
    parameter int AW      = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_stb,
    input  logic          bit_in,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int PW = $clog2(PRE_LEN + 1);
    localparam int CW = $clog2(DW);

    mdio_state_e   st_q, st_d;
    logic [PW-1:0] pre_q;
    logic [CW-1:0] cnt_q;
    logic          field_end;
    logic          pre_full;
    logic [DW-1:0] in_sh;
    logic [DW-1:0] out_sh;
    logic [1:0]    op_q;
    logic          hit_q;

    assign pre_full = (pre_q == PW'(PRE_LEN));

    always_comb begin
        unique case (st_q)
            ST_OP:   field_end = (cnt_q == CW'(1));
            ST_PHY:  field_end = (cnt_q == CW'(AW - 1));
            ST_REG:  field_end = (cnt_q == CW'(AW - 1));
            ST_TA:   field_end = (cnt_q == CW'(1));
            ST_DATA: field_end = (cnt_q == CW'(DW - 1));
            default: field_end = 1'b1;
        endcase
    end

    // next-state decision, evaluated on each bit strobe
    always_comb begin
        st_d = st_q;
        if (bit_stb) begin
            unique case (st_q)
                ST_PRE:   if (!bit_in && pre_full) st_d = ST_START;
                ST_START: st_d = bit_in ? ST_OP : ST_PRE;
                ST_OP:    if (field_end) st_d = ST_PHY;
                ST_PHY:   if (field_end) st_d = ST_REG;
                ST_REG:   if (field_end) st_d = ST_TA;
                ST_TA:    if (field_end) st_d = ST_DATA;
                ST_DATA:  if (field_end) st_d = ST_PRE;
                default:  st_d = ST_PRE;
            endcase
        end
    end

    // state register with its field and preamble counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_PRE;
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (bit_stb) begin
                cnt_q <= (st_d != st_q) ? '0 : cnt_q + CW'(1);
                if (st_q == ST_PRE && bit_in) begin
                    pre_q <= pre_full ? pre_q : pre_q + PW'(1);
                end else begin
                    pre_q <= '0;
                end
            end
        end
    end

    // read request fires on the first turnaround strobe of a matching read
    assign rd_req = bit_stb && (st_q == ST_TA) && (cnt_q == '0)
                    && (op_q == OP_RD) && hit_q;

    // outputs and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sh    <= '0;
            out_sh   <= '0;
            op_q     <= '0;
            hit_q    <= 1'b0;
            reg_addr <= '0;
            wr_data  <= '0;
            wr_req   <= 1'b0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (bit_stb) begin
                in_sh <= {in_sh[DW-2:0], bit_in};
                unique case (st_q)
                    ST_OP: begin
                        if (field_end) op_q <= {in_sh[0], bit_in};
                    end
                    ST_PHY: begin
                        if (field_end) hit_q <= ({in_sh[AW-2:0], bit_in} == my_addr);
                    end
                    ST_REG: begin
                        if (field_end) reg_addr <= {in_sh[AW-2:0], bit_in};
                    end
                    ST_TA: begin
                        if (rd_req) begin
                            out_sh  <= rd_data;
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                        end else if (mdio_oe) begin
                            mdio_o <= out_sh[DW-1];
                            out_sh <= {out_sh[DW-2:0], 1'b0};
                        end
                    end
                    ST_DATA: begin
                        if (field_end) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                            if (op_q == OP_WR && hit_q) begin
                                wr_req  <= 1'b1;
                                wr_data <= {in_sh[DW-2:0], bit_in};
                            end
                        end else if (mdio_oe) begin
                            mdio_o <= out_sh[DW-1];
                            out_sh <= {out_sh[DW-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: line driven only inside turnaround or data
    p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (st_q == ST_TA || st_q == ST_DATA));

    // R4: the first driven bit is a zero
    p_ta_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R11: read and write never coincide
    p_no_dual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R11: driving starts only for a matching read
    p_drive_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (hit_q && op_q == OP_RD));

endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we,
    input  logic [NEV-1:0] en_wdata,
    input  logic           pol_we,
    input  logic           pol_wdata,
    input  logic           clr,
    input  logic [NEV-1:0] evt,
    output logic [NEV-1:0] en_q,
    output logic [NEV-1:0] cond_q,
    output logic           pol_q,
    output logic           irq_o
);

    logic any_active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            cond_q <= '0;
            pol_q  <= 1'b0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (pol_we) pol_q <= pol_wdata;
            cond_q <= (cond_q & ~{NEV{clr}}) | evt;
        end
    end

    assign any_active = |(en_q & cond_q);
    assign irq_o      = pol_q ? any_active : ~any_active;

    // R8: without a clearing read no condition bit drops
    p_cond_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(cond_q) & ~cond_q) == '0));

    // R8: an event always lands, even in the clearing cycle
    p_evt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((cond_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [ADDR_W-1:0] strap_phyad,
    input  logic              strap_speed,
    input  logic              strap_duplex,
    input  logic              strap_aneg,
    input  logic              link_up,
    input  logic              aneg_done,
    input  logic [REG_W-1:0]  lp_ability,
    input  logic [REG_W/2-1:0] irq_evt,
    output logic              irq_o
);

    localparam int NEV = REG_W / 2;

    logic [SYNC_STAGES-1:0] mdc_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic                   mdc_prev;
    logic                   bit_stb;

    logic [ADDR_W-1:0] my_addr;
    logic [REG_W-1:0]  ctrl_seed, adv_seed;
    logic [REG_W-1:0]  ctrl_q, adv_q;
    logic [REG_W-1:0]  rd_data, wr_data;
    logic [ADDR_W-1:0] reg_addr;
    logic              rd_req, wr_req;
    logic [NEV-1:0]    en_q, cond_q;
    logic              pol_q;
    logic [REG_W-1:0]  stat_word;

    // bus synchronizer and rising-edge strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sync <= '0;
            dat_sync <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_sync <= {mdc_sync[SYNC_STAGES-2:0], mdc};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], mdio_i};
            mdc_prev <= mdc_sync[SYNC_STAGES-1];
        end
    end

    assign bit_stb = mdc_sync[SYNC_STAGES-1] & ~mdc_prev;

    phy_strap_latch #(.AW(ADDR_W), .RW(REG_W)) u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_phyad (strap_phyad),
        .strap_speed (strap_speed),
        .strap_duplex(strap_duplex),
        .strap_aneg  (strap_aneg),
        .my_addr     (my_addr),
        .ctrl_seed   (ctrl_seed),
        .adv_seed    (adv_seed)
    );

    phy_mdio_fsm #(.PRE_LEN(PRE_LEN), .DW(REG_W), .AW(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .bit_in  (dat_sync[SYNC_STAGES-1]),
        .my_addr (my_addr),
        .rd_data (rd_data),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    phy_irq_ctrl #(.NEV(NEV)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (wr_req && reg_addr == RA_IRQ),
        .en_wdata (wr_data[REG_W-1:NEV]),
        .pol_we   (wr_req && reg_addr == RA_MISC),
        .pol_wdata(wr_data[POL_BIT]),
        .clr      (rd_req && reg_addr == RA_IRQ),
        .evt      (irq_evt),
        .en_q     (en_q),
        .cond_q   (cond_q),
        .pol_q    (pol_q),
        .irq_o    (irq_o)
    );

    // writable registers, seeded from straps while reset is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_seed;
            adv_q  <= adv_seed;
        end else if (wr_req) begin
            if (reg_addr == RA_CTRL) ctrl_q <= wr_data & CTRL_WMASK;
            if (reg_addr == RA_ADV)  adv_q  <= wr_data & ADV_WMASK;
        end
    end

    always_comb begin
        stat_word    = STAT_FIXED;
        stat_word[2] = link_up;
        stat_word[5] = aneg_done;
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            RA_CTRL: rd_data = ctrl_q;
            RA_STAT: rd_data = stat_word;
            RA_ADV:  rd_data = adv_q | ADV_SEL;
            RA_LPA:  rd_data = lp_ability;
            RA_IRQ:  rd_data = {en_q, cond_q};
            RA_MISC: rd_data[POL_BIT] = pol_q;
            default: rd_data = '0;
        endcase
    end

    // R5: a write elsewhere leaves the advertisement untouched
    p_adv_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && reg_addr != RA_ADV) |=> $stable(adv_q));

    // R5: a write elsewhere leaves the control word untouched
    p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && reg_addr != RA_CTRL) |=> $stable(ctrl_q));

endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe;
    logic [4:0]  strap_phyad = 5'd1;
    logic        strap_speed = 1'b1, strap_duplex = 1'b1, strap_aneg = 1'b1;
    logic        link_up = 1'b1, aneg_done = 1'b0;
    logic [15:0] lp_ability = 16'hC5E1;
    logic [7:0]  irq_evt = 8'h00;
    logic        irq_o;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_ctrl, m_adv;
    logic [7:0]  m_en, m_cond;
    logic        m_pol;
    logic [4:0]  my_pa;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_regs uut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .strap_phyad(strap_phyad),
        .strap_speed(strap_speed), .strap_duplex(strap_duplex),
        .strap_aneg(strap_aneg), .link_up(link_up), .aneg_done(aneg_done),
        .lp_ability(lp_ability), .irq_evt(irq_evt), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic oe_s, output logic o_s);
        mdio_i = b;
        repeat (3) @(negedge clk);
        oe_s = mdio_oe;
        o_s  = mdio_o;
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input int pre, input bit exp_drive,
                             output logic [15:0] rd, output bit bad);
        logic [31:0] w;
        logic oe_s, o_s, b;
        w = {2'b01, op, pa, ra, 2'b10, wd};
        bad = 0;
        rd = '0;
        for (int i = 0; i < pre; i++) begin
            send_bit(1'b1, oe_s, o_s);
            if (oe_s) bad = 1;
        end
        for (int p = 0; p < 32; p++) begin
            b = (op == 2'b10 && p >= 14) ? 1'b1 : w[31-p];
            send_bit(b, oe_s, o_s);
            if (oe_s !== (exp_drive && p >= 15)) bad = 1;
            if (p == 15 && exp_drive && o_s !== 1'b0) bad = 1;
            if (p >= 16) rd = {rd[14:0], o_s};
        end
        send_bit(1'b1, oe_s, o_s);
        if (oe_s) bad = 1;
    endtask

    function automatic logic [15:0] model_read(input logic [4:0] ra);
        case (ra)
            5'h00: return m_ctrl;
            5'h01: return 16'hF009 | (16'(link_up) << 2) | (16'(aneg_done) << 5);
            5'h04: return m_adv | 16'h0001;
            5'h05: return lp_ability;
            5'h1B: return {m_en, m_cond};
            5'h1F: return 16'(m_pol) << 9;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_pol ? |(m_en & m_cond) : ~|(m_en & m_cond);
    endfunction

    task automatic do_read(input string tag, input logic [4:0] pa, input logic [4:0] ra);
        logic [15:0] rd, ex;
        bit bad;
        bit hit;
        hit = (pa == my_pa);
        ex  = model_read(ra);
        run_frame(2'b10, pa, ra, 16'h0, 32, hit, rd, bad);
        chk({tag, " drive window"}, 32'(bad), 32'd0);
        if (hit) begin
            chk({tag, " data"}, 32'(rd), 32'(ex));
            if (ra == 5'h1B) m_cond = irq_evt;
        end
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] rd;
        bit bad;
        run_frame(2'b01, pa, ra, wd, 32, 1'b0, rd, bad);
        chk("R11 write never drives", 32'(bad), 32'd0);
        if (pa == my_pa) begin
            case (ra)
                5'h00: m_ctrl = wd & 16'h7D00;
                5'h04: m_adv  = wd & 16'h01E0;
                5'h1B: m_en   = wd[15:8];
                5'h1F: m_pol  = wd[9];
                default: ;
            endcase
        end
    endtask

    task automatic pulse_evt(input logic [7:0] v);
        @(negedge clk) irq_evt = v;
        @(negedge clk) irq_evt = 8'h00;
        m_cond = m_cond | v;
        repeat (2) @(negedge clk);
    endtask

    task automatic apply_reset(input logic [4:0] pa, input logic s, input logic d, input logic a);
        strap_phyad = pa; strap_speed = s; strap_duplex = d; strap_aneg = a;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        my_pa  = pa;
        m_ctrl = {2'b00, s, a, 3'b000, d, 8'h00};
        m_adv  = {7'b0, s & d, s, d, 1'b1, 5'b0};
        m_en = 8'h00; m_cond = 8'h00; m_pol = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        bit bad;
        void'($urandom(32'd2024));
        apply_reset(5'd1, 1'b1, 1'b1, 1'b1);

        // reset state
        chk("R9 idle pin high after reset", 32'(irq_o), 32'd1);
        chk("R4 line released after reset", 32'(mdio_oe), 32'd0);

        // R2 R3 R7 strapped defaults and read-only words
        do_read("R2 control default", 5'd1, 5'h00);
        do_read("R3 advert default", 5'd1, 5'h04);
        do_read("R7 status", 5'd1, 5'h01);
        aneg_done = 1'b1; link_up = 1'b0;
        do_read("R7 status toggled", 5'd1, 5'h01);
        do_read("R7 partner", 5'd1, 5'h05);

        // R1 foreign address: no drive, no write
        do_read("R1 foreign read", 5'd2, 5'h00);
        do_write(5'd2, 5'h00, 16'h0000);
        do_read("R1 after foreign write", 5'd1, 5'h00);

        // R5 masks and read-only words
        do_write(5'd1, 5'h00, 16'hFFFF);
        do_read("R5 control mask", 5'd1, 5'h00);
        do_write(5'd1, 5'h01, 16'h0000);
        do_read("R5 status write ignored", 5'd1, 5'h01);
        do_write(5'd1, 5'h05, 16'h0000);
        do_read("R5 partner write ignored", 5'd1, 5'h05);
        do_write(5'd1, 5'h04, 16'hFFFF);
        do_read("R5 advert mask", 5'd1, 5'h04);

        // R6 unimplemented space
        do_write(5'd1, 5'h10, 16'h1234);
        do_read("R6 unmapped reads zero", 5'd1, 5'h10);

        // R10 short preamble and illegal opcodes
        run_frame(2'b01, 5'd1, 5'h00, 16'h0000, 20, 1'b0, rd, bad);
        chk("R10 short preamble no drive", 32'(bad), 32'd0);
        do_read("R10 short preamble ignored", 5'd1, 5'h00);
        run_frame(2'b11, 5'd1, 5'h00, 16'h0000, 32, 1'b0, rd, bad);
        chk("R10 opcode 11 no drive", 32'(bad), 32'd0);
        run_frame(2'b00, 5'd1, 5'h00, 16'h0000, 32, 1'b0, rd, bad);
        chk("R10 opcode 00 no drive", 32'(bad), 32'd0);
        do_read("R10 bad opcode ignored", 5'd1, 5'h00);

        // R8 R9 interrupt path
        pulse_evt(8'h04);
        chk("R9 disabled condition keeps pin idle", 32'(irq_o), 32'd1);
        do_read("R8 condition latched", 5'd1, 5'h1B);
        do_read("R8 cleared by read", 5'd1, 5'h1B);
        do_write(5'd1, 5'h1B, 16'h04FF);
        do_read("R5 irq enable mask", 5'd1, 5'h1B);
        pulse_evt(8'h04);
        chk("R9 active low assert", 32'(irq_o), 32'd0);
        do_write(5'd1, 5'h1F, 16'hFFFF);
        do_read("R5 misc mask", 5'd1, 5'h1F);
        chk("R9 active high assert", 32'(irq_o), 32'd1);
        do_read("R8 read before clear", 5'd1, 5'h1B);
        chk("R9 active high released", 32'(irq_o), 32'd0);

        // R8 event held through the clearing read stays set
        @(negedge clk) irq_evt = 8'h08;
        m_cond = m_cond | 8'h08;
        repeat (2) @(negedge clk);
        do_read("R8 read with event held", 5'd1, 5'h1B);
        @(negedge clk) irq_evt = 8'h00;
        m_cond = 8'h08;
        do_read("R8 same-cycle event survives", 5'd1, 5'h1B);

        // seeded random mix
        for (int k = 0; k < 40; k++) begin
            logic [4:0] ra, pa;
            logic [15:0] wd;
            int sel;
            if ($urandom % 3 == 0) pulse_evt(8'($urandom));
            sel = int'($urandom % 7);
            case (sel)
                0: ra = 5'h00; 1: ra = 5'h01; 2: ra = 5'h04; 3: ra = 5'h05;
                4: ra = 5'h1B; 5: ra = 5'h1F; default: ra = 5'h08 | 5'($urandom % 8);
            endcase
            pa = ($urandom % 5 == 0) ? (my_pa ^ 5'(1 + $urandom % 31)) : my_pa;
            wd = 16'($urandom);
            link_up = 1'($urandom);
            if ($urandom % 2 == 0) do_write(pa, ra, wd);
            else do_read("R7 random read", pa, ra);
            chk("R9 random pin level", 32'(irq_o), 32'(exp_irq()));
        end

        // second reset with other straps
        apply_reset(5'h1A, 1'b0, 1'b1, 1'b0);
        do_read("R2 control from straps", 5'h1A, 5'h00);
        do_read("R3 advert from straps", 5'h1A, 5'h04);
        do_read("R1 old address ignored", 5'd1, 5'h00);
        chk("R9 pin idle after second reset", 32'(irq_o), 32'd1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule